// File: doc/BRIEF.md
# Dual-Source Relay Output Register Bank

This block is a byte-wide register bank on a small legacy I/O bus with a plain strobe interface: an address, a write strobe, a read strobe, write data and combinational read data. It recognises two addresses above a fixed I/O base. The first address holds a write-only control byte that sets four relay outputs and two modem power-control lines. The second address returns a read-only status byte with the levels of four external inputs.

A second host interface has its own 4-bit relay register, written through a write enable and a data port. Each relay closes when either host requests it, so the two pieces of software never need to coordinate. The external inputs pass through a two-flop synchroniser and are returned without filtering. Any debouncing is left to software.

Top module: `relay_io_bank`

## Requirements
- R1: Only a write strobe at address BASE+1 (default 0x301) changes the control byte; writes to any other address, including 0x300 and 0x303, leave every output unchanged.
- R2: Control byte bits 0 to 3 drive relay_out[0] to relay_out[3], where 1 means closed. The output changes on the clock edge that captures the write.
- R3: Control byte bit 6 drives modem_on and bit 7 drives modem_eoff, both active high. Bits 4 and 5 are discarded and affect no output.
- R4: relay_out[n] is 1 whenever bit n is 1 in the legacy control byte or in the second-interface relay register.
- R5: A second-interface write (alt_we with alt_wdata) replaces only that interface's relay register. It never alters the legacy byte, the modem lines, or the other source's relay requests.
- R6: A read strobe at BASE+2 returns {4'b0000, synchronised in_raw[3:0]}, with bit n equal to the level of input n (1 = high). No filtering is applied.
- R7: A change on in_raw that is present at clock edge k appears in the status byte after edge k+1, and not earlier.
- R8: bus_rdata is 0xFF whenever no read strobe at BASE+2 is present, including reads of BASE+1. A write to BASE+2 changes no output.
- R9: A synchronous active-high reset opens all relays, clears both relay registers, sets modem_on to 1, clears modem_eoff, and clears the synchroniser.
- R10: A legacy write and a second-interface write in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| alt_we | input | 1 | Second-interface relay write enable |
| alt_wdata | input | 4 | Second-interface relay data |
| in_raw | input | 4 | Asynchronous external inputs |
| relay_out | output | 4 | Relay drive, 1 = closed |
| modem_on | output | 1 | Modem power-on line |
| modem_eoff | output | 1 | Modem emergency-off line |

## Verification
A legacy control write and a second-interface relay write can land on the same clock edge. A read of the status byte can also coincide with a change on the inputs, and a write strobe can coincide with a read strobe. The random phase drives the legacy strobes, alt_we and in_raw independently on every cycle, so all of these overlaps occur many times. Directed cases force the collisions explicitly. Each cycle the outputs are compared with a bench model that keeps two relay sources, ORs them, and delays the inputs through two stages. A collision passes only when both writes are visible after the edge and the read returns the value delayed by two stages.

// File: rtl/relay_io_pkg.sv
package relay_io_pkg;
    localparam int unsigned OFS_CTRL   = 1;
    localparam int unsigned OFS_STAT   = 2;
    localparam logic [7:0]  CTRL_RESET = 8'h40;
    localparam logic [7:0]  CTRL_MASK  = 8'hCF;
    localparam logic [7:0]  RD_IDLE    = 8'hFF;
    localparam int unsigned BIT_ON     = 6;
    localparam int unsigned BIT_EOFF   = 7;
endpackage

// File: rtl/relay_io_decode.sv
module relay_io_decode #(
    parameter int unsigned AW   = 16,
    parameter int unsigned BASE = 16'h0300
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    output logic          ctrl_wr_hit,
    output logic          stat_rd_hit
);
    import relay_io_pkg::*;

    localparam logic [AW-1:0] ADR_CTRL = AW'(BASE + OFS_CTRL);
    localparam logic [AW-1:0] ADR_STAT = AW'(BASE + OFS_STAT);

    always_comb begin
        ctrl_wr_hit = wr && (addr == ADR_CTRL);
        stat_rd_hit = rd && (addr == ADR_STAT);
    end
endmodule

// File: rtl/relay_io_sync.sv
module relay_io_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [1:0]   age;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = raw;
        st_d.s2  = st_q.s1;
        if (st_q.age != 2'd2) st_d.age = st_q.age + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign synced = st_q.s2;

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        (st_q.age == 2'd2) |-> (synced == $past(raw, 2))); // R7
endmodule

// File: rtl/relay_io_outreg.sv
module relay_io_outreg #(
    parameter int unsigned DW       = 8,
    parameter int unsigned REL_N    = 4,
    parameter int unsigned ON_BIT   = 6,
    parameter int unsigned EOFF_BIT = 7,
    parameter logic [7:0]  RST_VAL  = 8'h40,
    parameter logic [7:0]  WMASK    = 8'hCF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             leg_we,
    input  logic [DW-1:0]    leg_wdata,
    input  logic             alt_we,
    input  logic [REL_N-1:0] alt_wdata,
    output logic [REL_N-1:0] relay,
    output logic             modem_on,
    output logic             modem_eoff
);
    typedef struct packed {
        logic [DW-1:0]    leg;
        logic [REL_N-1:0] alt;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (leg_we) st_d.leg = leg_wdata & DW'(WMASK);
        if (alt_we) st_d.alt = alt_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.leg <= DW'(RST_VAL);
            st_q.alt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < REL_N; i++) begin : g_merge
        assign relay[i] = st_q.leg[i] | st_q.alt[i];
    end

    assign modem_on   = st_q.leg[ON_BIT];
    assign modem_eoff = st_q.leg[EOFF_BIT];

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (relay == '0 && modem_on && !modem_eoff)); // R9
    AST_LEG_RELAY: assert property (@(posedge clk) disable iff (rst)
        leg_we |=> ((relay & $past(leg_wdata[REL_N-1:0])) == $past(leg_wdata[REL_N-1:0]))); // R2
    AST_LEG_MODEM: assert property (@(posedge clk) disable iff (rst)
        leg_we |=> (modem_on == $past(leg_wdata[ON_BIT]) && modem_eoff == $past(leg_wdata[EOFF_BIT]))); // R3
    AST_ALT_OR: assert property (@(posedge clk) disable iff (rst)
        alt_we |=> ((relay & $past(alt_wdata)) == $past(alt_wdata))); // R4
    AST_ALT_KEEPS_MODEM: assert property (@(posedge clk) disable iff (rst)
        (alt_we && !leg_we) |=> ($stable(modem_on) && $stable(modem_eoff))); // R5
endmodule

// File: rtl/relay_io_bank.sv
module relay_io_bank #(
    parameter int unsigned AW    = 16,
    parameter int unsigned BASE  = 16'h0300,
    parameter int unsigned DW    = 8,
    parameter int unsigned REL_N = 4,
    parameter int unsigned IN_N  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             alt_we,
    input  logic [REL_N-1:0] alt_wdata,
    input  logic [IN_N-1:0]  in_raw,
    output logic [REL_N-1:0] relay_out,
    output logic             modem_on,
    output logic             modem_eoff
);
    import relay_io_pkg::*;

    localparam logic [AW-1:0] ADR_STAT = AW'(BASE + OFS_STAT);

    logic            ctrl_wr_hit;
    logic            stat_rd_hit;
    logic [IN_N-1:0] in_sync;

    relay_io_decode #(.AW(AW), .BASE(BASE)) i_decode (
        .addr        (bus_addr),
        .wr          (bus_wr),
        .rd          (bus_rd),
        .ctrl_wr_hit (ctrl_wr_hit),
        .stat_rd_hit (stat_rd_hit)
    );

    relay_io_sync #(.W(IN_N)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    (in_raw),
        .synced (in_sync)
    );

    relay_io_outreg #(
        .DW(DW), .REL_N(REL_N), .ON_BIT(BIT_ON), .EOFF_BIT(BIT_EOFF),
        .RST_VAL(CTRL_RESET), .WMASK(CTRL_MASK)
    ) i_outreg (
        .clk        (clk),
        .rst        (rst),
        .leg_we     (ctrl_wr_hit),
        .leg_wdata  (bus_wdata),
        .alt_we     (alt_we),
        .alt_wdata  (alt_wdata),
        .relay      (relay_out),
        .modem_on   (modem_on),
        .modem_eoff (modem_eoff)
    );

    always_comb begin
        bus_rdata = DW'(RD_IDLE);
        if (stat_rd_hit) bus_rdata = DW'(in_sync);
    end

    AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_addr == ADR_STAT) |-> (bus_rdata == DW'(RD_IDLE))); // R8
    AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADR_STAT) |-> (bus_rdata[DW-1:IN_N] == '0)); // R6
endmodule

// File: tb/test_relay_io_bank.sv
module test_relay_io_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        alt_we = 1'b0;
    logic [3:0]  alt_wdata = '0;
    logic [3:0]  in_raw = '0;
    logic [3:0]  relay_out;
    logic        modem_on;
    logic        modem_eoff;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_leg;
    logic [3:0] m_alt;
    logic [3:0] m_s1, m_s2;

    always #2.5 clk = ~clk;

    relay_io_bank i_relay_io_bank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_we(alt_we), .alt_wdata(alt_wdata),
        .in_raw(in_raw), .relay_out(relay_out), .modem_on(modem_on), .modem_eoff(modem_eoff)
    );

    function automatic logic [3:0] exp_relay();
        return m_leg[3:0] | m_alt;
    endfunction

    function automatic logic [7:0] exp_rdata();
        if (bus_rd && bus_addr == 16'h0302) return {4'b0000, m_s2};
        return 8'hFF;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, {4'b0, relay_out}, {4'b0, exp_relay()});
        chk(req, {6'b0, modem_eoff, modem_on}, {6'b0, m_leg[7], m_leg[6]});
        chk(req, bus_rdata, exp_rdata());
    endtask

    // one clock: model follows applied inputs, then outputs checked at negedge
    task automatic step(input string req);
        @(posedge clk);
        if (rst) begin
            m_leg = 8'h40; m_alt = '0; m_s1 = '0; m_s2 = '0;
        end else begin
            if (bus_wr && bus_addr == 16'h0301) m_leg = bus_wdata & 8'hCF;
            if (alt_we) m_alt = alt_wdata;
            m_s2 = m_s1; m_s1 = in_raw;
        end
        @(negedge clk);
        check_all(req);
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; alt_we = 0; bus_addr = '0; bus_wdata = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_leg = 8'h40; m_alt = '0; m_s1 = '0; m_s2 = '0;
        @(negedge clk);
        step("R9 reset"); step("R9 reset");
        rst = 0;
        chk("R9 relays open", {4'b0, relay_out}, 8'h00);
        chk("R9 modem_on", {7'b0, modem_on}, 8'h01);
        chk("R9 modem_eoff", {7'b0, modem_eoff}, 8'h00);

        // R2 R3: legacy write with unused bits 4,5 set
        bus_addr = 16'h0301; bus_wr = 1; bus_wdata = 8'hB5;
        step("R2 R3 legacy write");
        idle();
        chk("R2 relay bits", {4'b0, relay_out}, 8'h05);
        chk("R3 modem lines", {6'b0, modem_eoff, modem_on}, 8'h02);

        // R1: writes to neighbouring addresses ignored
        bus_wr = 1; bus_wdata = 8'h0F; bus_addr = 16'h0300; step("R1 base+0 ignored");
        bus_addr = 16'h0303; step("R1 base+3 ignored");
        bus_addr = 16'h0401; step("R1 other page ignored");
        idle();
        chk("R1 relays unchanged", {4'b0, relay_out}, 8'h05);

        // R8: write to status address has no effect; read of control address gives FF
        bus_addr = 16'h0302; bus_wr = 1; bus_wdata = 8'hFF; step("R8 write to status");
        idle();
        chk("R8 relays unchanged", {4'b0, relay_out}, 8'h05);
        bus_addr = 16'h0301; bus_rd = 1; #1;
        chk("R8 read of control", bus_rdata, 8'hFF);
        idle();

        // R4 R5: second interface ORs in, legacy clear leaves it
        alt_we = 1; alt_wdata = 4'hA; step("R4 alt write"); idle();
        chk("R4 OR", {4'b0, relay_out}, 8'h0F);
        bus_addr = 16'h0301; bus_wr = 1; bus_wdata = 8'h00; step("R5 legacy clear"); idle();
        chk("R5 alt kept", {4'b0, relay_out}, 8'h0A);
        chk("R5 modem from legacy", {7'b0, modem_on}, 8'h00);
        alt_we = 1; alt_wdata = 4'h0; step("R5 alt clear"); idle();
        chk("R5 modem unchanged", {7'b0, modem_on}, 8'h00);

        // R10: simultaneous writes
        bus_addr = 16'h0301; bus_wr = 1; bus_wdata = 8'hC1; alt_we = 1; alt_wdata = 4'h4;
        step("R10 same cycle"); idle();
        chk("R10 both", {4'b0, relay_out}, 8'h05);
        chk("R10 modem", {6'b0, modem_eoff, modem_on}, 8'h03);

        // R6 R7: two-stage latency
        in_raw = 4'h0; bus_addr = 16'h0302; bus_rd = 1;
        step("R7 settle"); step("R7 settle"); step("R7 settle");
        in_raw = 4'hA; step("R7 edge1");
        chk("R7 not yet", bus_rdata, 8'h00);
        step("R6 R7 edge2");
        chk("R6 R7 visible", bus_rdata, 8'h0A);
        idle();

        // random phase
        for (int it = 0; it < 3000; it++) begin
            int sel;
            sel = int'($urandom % 6);
            case (sel)
                0: bus_addr = 16'h0301;
                1: bus_addr = 16'h0302;
                2: bus_addr = 16'h0300;
                3: bus_addr = 16'h0303;
                4: bus_addr = 16'h0301 ^ (16'h1 << ($urandom % 16));
                default: bus_addr = 16'($urandom);
            endcase
            bus_wr = 1'($urandom); bus_rd = 1'($urandom);
            bus_wdata = 8'($urandom);
            alt_we = ($urandom % 3) == 0; alt_wdata = 4'($urandom);
            in_raw = 4'($urandom);
            #1; chk("R6 R8 random read", bus_rdata, exp_rdata());
            step("R1 R2 R3 R4 R5 R10 random");
            if (it == 1500) begin
                rst = 1; step("R9 mid reset"); rst = 0;
                chk("R9 mid modem_on", {7'b0, modem_on}, 8'h01);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule